// File: doc/BRIEF.md
# Repeating Loop-Code Detector

This block watches a received bit-serial line stream and reports whether one of three programmed repeating codes is present. The three detectors are named up, down and spare. Each one has its own code bytes and its own length setting. A pattern can be 1 to 8 bits long or 16 bits long. Each detector compares every received bit against the bit it expects next in its pattern. A small phase index tracks the position in the pattern. The detector counts mismatches over a fixed window of received bits. A code is declared present when a window ends with no more than about 2% mismatches. It is declared absent when a window ends above that limit. If a window fails, the phase index slips by one extra position, so a stream that starts out of alignment is picked up within a few windows. The window length is a parameter. The default is 74112 bits, which is 48 ms at 1.544 Mb/s.

A frame-bit marker comes with each received bit. In insert mode a marked bit is not part of the pattern, and it is dropped. In overwrite mode a marked bit takes one pattern position but never counts as a mismatch. Software programs the block through a byte-wide register port. It reads back a real-time status byte and two latched event bytes: one records detections that began, the other records detections that ended. It also sets a mask that routes the latched events to an interrupt line.

Top module: `loopcode_detector`

## Requirements
- R1: Length register d (addresses 0, 1, 2 for up, down, spare) holds a 4-bit value n. For n = 0..7 the pattern length is n+1 and the pattern is bits [n:0] of the first code byte, sent most significant bit first. For n = 8..15 the pattern is 16 bits long, with the first code byte followed by the second, each sent most significant bit first. The first and second code bytes of detector d are at addresses 4+2d and 5+2d.
- R2: After a restart, a detector's status bit changes only on the last counted bit of each window of WINDOW_BITS counted bits. It does not change earlier. Real-time status is at address 10, with bit d for detector d.
- R3: At the end of a window, the status bit is set if the mismatch count is at most WINDOW_BITS/50. Otherwise it is cleared.
- R4: When bit 0 of the mode register (address 3) is 1, a bit that arrives with the frame marker set is ignored. It does not advance the phase and does not count toward the window.
- R5: When the mode bit is 0, a marked bit advances the phase and counts toward the window. It is never counted as a mismatch.
- R6: Writing a detector's first code byte or its length register restarts that detector's window and phase.
- R7: A rise of status bit d sets bit d of the latched-set byte (address 11) one cycle later. A fall sets bit d of the latched-clear byte (address 12) one cycle later. A read strobe at either address clears that byte, but an event in the same cycle wins over the clear.
- R8: `irq` is high exactly when a latched-set bit is enabled by mask bit d, or a latched-clear bit is enabled by mask bit d+4. The mask is at address 13.
- R9: After reset, all status, latched, mask and mode bits are 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitIn | input | 1 | Received line bit |
| bitValid | input | 1 | bitIn holds a new bit this cycle |
| frameMark | input | 1 | The current bit is a frame bit |
| regAddr | input | 4 | Register address for writes and reads |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| rdEn | input | 1 | Read strobe, used to clear the latched bytes |
| rdData | output | 8 | Read data for regAddr (combinational) |
| irq | output | 1 | Interrupt from the masked latched events |

## Verification
The assertions check on every cycle that each rise or fall of a status bit lands in its latched byte one cycle later, even when a read-clear arrives in the same cycle. They also check that latched bits stay set until they are read, that status never moves on a cycle with no received bit, and that the interrupt is never raised without a latched event. Other behaviours need the bench's scenarios, because they depend on whole windows of traffic:
- where the window boundary falls;
- the exact mismatch threshold;
- the two frame-bit modes;
- the restart caused by a register write;
- the length encodings.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  localparam int NUM_DET = 3;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] ADDR_LEN_BASE  = 4'd0;
  localparam logic [ADDR_W-1:0] ADDR_MODE      = 4'd3;
  localparam logic [ADDR_W-1:0] ADDR_CODE_BASE = 4'd4;
  localparam logic [ADDR_W-1:0] ADDR_RT        = 4'd10;
  localparam logic [ADDR_W-1:0] ADDR_LSET      = 4'd11;
  localparam logic [ADDR_W-1:0] ADDR_LCLR      = 4'd12;
  localparam logic [ADDR_W-1:0] ADDR_MASK      = 4'd13;

  // Per-cycle strobes from the control module to the datapath
  typedef struct packed {
    logic [NUM_DET-1:0] restart;  // restart window and phase
    logic               takeBit;  // bit counts toward the window
    logic               noErr;    // bit is excluded from the mismatch count
  } ctlStrobes_t;
endpackage

// File: rtl/lcd_datapath.sv
module lcd_datapath
  import lcd_pkg::*;
#(
  parameter int WINDOW_BITS = 74112
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctlStrobes_t                   strobes,
  input  logic                          bitIn,
  input  logic [NUM_DET-1:0][7:0]       codeLo,
  input  logic [NUM_DET-1:0][7:0]       codeHi,
  input  logic [NUM_DET-1:0][3:0]       lenSel,
  output logic [NUM_DET-1:0]            present
);
  localparam int ERR_LIMIT = WINDOW_BITS / 50;
  localparam int CNT_W = $clog2(WINDOW_BITS + 1);
  localparam int ERR_W = $clog2(ERR_LIMIT + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WINDOW_BITS - 1);
  localparam logic [ERR_W-1:0] ERR_MAX = ERR_W'(ERR_LIMIT);

  for (genvar d = 0; d < NUM_DET; d++) begin : g_det
    logic [CNT_W-1:0] bitCnt;
    logic [ERR_W-1:0] errCnt, errNext;
    logic [3:0]       phase;
    logic [4:0]       patLen, idx, sum1, sum2, phaseNext;
    logic [15:0]      pat;
    logic             expBit, mismatch, winEnd, winFail;

    always_comb begin
      patLen   = lenSel[d][3] ? 5'd16 : ({2'b00, lenSel[d][2:0]} + 5'd1);
      pat      = lenSel[d][3] ? {codeLo[d], codeHi[d]} : {8'h00, codeLo[d]};
      idx      = patLen - 5'd1 - {1'b0, phase};
      expBit   = pat[idx[3:0]];
      mismatch = strobes.takeBit && !strobes.noErr && (bitIn != expBit);
      errNext  = (errCnt > ERR_MAX) ? errCnt : errCnt + ERR_W'(mismatch);
      winEnd   = strobes.takeBit && (bitCnt == LAST_BIT);
      winFail  = errNext > ERR_MAX;
      // slip one extra position after a failed window to hunt for alignment
      sum1     = {1'b0, phase} + ((winEnd && winFail) ? 5'd2 : 5'd1);
      sum2     = (sum1 >= patLen) ? sum1 - patLen : sum1;
      phaseNext = (sum2 >= patLen) ? sum2 - patLen : sum2;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bitCnt     <= '0;
        errCnt     <= '0;
        phase      <= '0;
        present[d] <= 1'b0;
      end else if (strobes.restart[d]) begin
        bitCnt <= '0;
        errCnt <= '0;
        phase  <= '0;
      end else if (strobes.takeBit) begin
        phase <= phaseNext[3:0];
        if (winEnd) begin
          bitCnt     <= '0;
          errCnt     <= '0;
          present[d] <= !winFail;
        end else begin
          bitCnt <= bitCnt + 1'b1;
          errCnt <= errNext;
        end
      end
    end
  end
endmodule

// File: rtl/lcd_control.sv
module lcd_control
  import lcd_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     bitValid,
  input  logic                     frameMark,
  input  logic [ADDR_W-1:0]        regAddr,
  input  logic                     wrEn,
  input  logic [7:0]               wrData,
  input  logic                     rdEn,
  input  logic [NUM_DET-1:0]       present,
  output ctlStrobes_t              strobes,
  output logic [NUM_DET-1:0][7:0]  codeLo,
  output logic [NUM_DET-1:0][7:0]  codeHi,
  output logic [NUM_DET-1:0][3:0]  lenSel,
  output logic [NUM_DET-1:0]       latSet,
  output logic [NUM_DET-1:0]       latClr,
  output logic [7:0]               rdData,
  output logic                     irq
);
  logic               insertMode;
  logic [7:0]         maskReg;
  logic [NUM_DET-1:0] prevRt, setEv, clrEv;
  logic               rdSet, rdClr;

  for (genvar d = 0; d < NUM_DET; d++) begin : g_cfg
    localparam logic [ADDR_W-1:0] LEN_A = ADDR_LEN_BASE + ADDR_W'(d);
    localparam logic [ADDR_W-1:0] LO_A  = ADDR_CODE_BASE + ADDR_W'(2 * d);
    localparam logic [ADDR_W-1:0] HI_A  = ADDR_CODE_BASE + ADDR_W'(2 * d + 1);

    assign strobes.restart[d] = wrEn && (regAddr == LO_A || regAddr == LEN_A);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lenSel[d] <= '0;
        codeLo[d] <= '0;
        codeHi[d] <= '0;
      end else if (wrEn) begin
        if (regAddr == LEN_A) lenSel[d] <= wrData[3:0];
        if (regAddr == LO_A)  codeLo[d] <= wrData;
        if (regAddr == HI_A)  codeHi[d] <= wrData;
      end
    end
  end

  assign strobes.takeBit = bitValid && !(frameMark && insertMode);
  assign strobes.noErr   = frameMark && !insertMode;

  assign setEv = present & ~prevRt;
  assign clrEv = ~present & prevRt;
  assign rdSet = rdEn && regAddr == ADDR_LSET;
  assign rdClr = rdEn && regAddr == ADDR_LCLR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      insertMode <= 1'b0;
      maskReg    <= '0;
      prevRt     <= '0;
      latSet     <= '0;
      latClr     <= '0;
    end else begin
      if (wrEn && regAddr == ADDR_MODE) insertMode <= wrData[0];
      if (wrEn && regAddr == ADDR_MASK) maskReg <= wrData;
      prevRt <= present;
      latSet <= (rdSet ? '0 : latSet) | setEv;
      latClr <= (rdClr ? '0 : latClr) | clrEv;
    end
  end

  assign irq = |(latSet & maskReg[NUM_DET-1:0]) | |(latClr & maskReg[4+NUM_DET-1:4]);

  always_comb begin
    rdData = 8'h00;
    case (regAddr)
      4'd0, 4'd1, 4'd2: rdData = {4'h0, lenSel[regAddr[1:0]]};
      ADDR_MODE:        rdData = {7'h00, insertMode};
      4'd4:             rdData = codeLo[0];
      4'd5:             rdData = codeHi[0];
      4'd6:             rdData = codeLo[1];
      4'd7:             rdData = codeHi[1];
      4'd8:             rdData = codeLo[2];
      4'd9:             rdData = codeHi[2];
      ADDR_RT:          rdData = {5'h00, present};
      ADDR_LSET:        rdData = {5'h00, latSet};
      ADDR_LCLR:        rdData = {5'h00, latClr};
      ADDR_MASK:        rdData = maskReg;
      default:          rdData = 8'h00;
    endcase
  end
endmodule

// File: rtl/loopcode_detector.sv
module loopcode_detector
  import lcd_pkg::*;
#(
  parameter int WINDOW_BITS = 74112
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitIn,
  input  logic        bitValid,
  input  logic        frameMark,
  input  logic [3:0]  regAddr,
  input  logic        wrEn,
  input  logic [7:0]  wrData,
  input  logic        rdEn,
  output logic [7:0]  rdData,
  output logic        irq
);
  ctlStrobes_t              strobes;
  logic [NUM_DET-1:0][7:0]  codeLo, codeHi;
  logic [NUM_DET-1:0][3:0]  lenSel;
  logic [NUM_DET-1:0]       present, latSet, latClr;

  lcd_control u_ctl (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .frameMark(frameMark),
    .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .present(present), .strobes(strobes), .codeLo(codeLo), .codeHi(codeHi),
    .lenSel(lenSel), .latSet(latSet), .latClr(latClr), .rdData(rdData), .irq(irq)
  );

  lcd_datapath #(.WINDOW_BITS(WINDOW_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .bitIn(bitIn),
    .codeLo(codeLo), .codeHi(codeHi), .lenSel(lenSel), .present(present)
  );
endmodule

// File: rtl/lcd_checker.sv
module lcd_checker (
  input logic       clk,
  input logic       rstN,
  input logic       bitValid,
  input logic       rdEn,
  input logic [3:0] regAddr,
  input logic       irq,
  input logic [2:0] rt,
  input logic [2:0] latSet,
  input logic [2:0] latClr
);
  for (genvar d = 0; d < 3; d++) begin : g_chk
    AST_SET_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
      $rose(rt[d]) |=> latSet[d]);  // R7
    AST_CLR_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
      $fell(rt[d]) |=> latClr[d]);  // R7
    AST_SET_HELD: assert property (@(posedge clk) disable iff (!rstN)
      (latSet[d] && !(rdEn && regAddr == 4'd11)) |=> latSet[d]);  // R7
    AST_CLR_HELD: assert property (@(posedge clk) disable iff (!rstN)
      (latClr[d] && !(rdEn && regAddr == 4'd12)) |=> latClr[d]);  // R7
  end

  AST_RT_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rstN)
    !bitValid |=> $stable(rt));  // R2
  AST_IRQ_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    (latSet == 3'b000 && latClr == 3'b000) |-> !irq);  // R8
endmodule

bind loopcode_detector lcd_checker u_chk (
  .clk(clk), .rstN(rstN), .bitValid(bitValid), .rdEn(rdEn), .regAddr(regAddr),
  .irq(irq), .rt(present), .latSet(latSet), .latClr(latClr)
);

// File: tb/loopcode_detector_bench.sv
`timescale 1ns/1ps
module loopcode_detector_bench;
  localparam int W = 200;

  logic clk = 1'b0, rstN = 1'b0;
  logic bitIn = 1'b0, bitValid = 1'b0, frameMark = 1'b0;
  logic [3:0] regAddr = 4'd0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic irq;

  int checks = 0, errors = 0, ph = 0;

  typedef struct {
    logic [3:0] addr;
    logic       clr;
    logic       irqChk;
    logic [7:0] exp;
    string      req;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  loopcode_detector #(.WINDOW_BITS(W)) u_loopcode_detector (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .bitValid(bitValid), .frameMark(frameMark),
    .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .irq(irq)
  );

  // monitor: pops expected items and compares against the read port / irq
  initial begin
    item_t it;
    logic [7:0] got;
    forever begin
      @(negedge clk);
      rdEn = 1'b0;
      if (q.size() > 0) begin
        it = q.pop_front();
        regAddr = it.addr;
        rdEn = it.clr;
        #1;
        got = it.irqChk ? {7'd0, irq} : rdData;
        checks++;
        if (got !== it.exp) begin
          errors++;
          $display("FAIL %s addr %0d actual %h expected %h", it.req, it.addr, got, it.exp);
        end
      end
    end
  end

  task automatic expectReg(input logic [3:0] a, input logic [7:0] e, input string r,
                           input logic clr = 1'b0);
    item_t it;
    it.addr = a; it.clr = clr; it.irqChk = 1'b0; it.exp = e; it.req = r;
    q.push_back(it);
    wait (q.size() == 0);
    @(posedge clk);
  endtask

  task automatic expectIrq(input logic e, input string r);
    item_t it;
    it.addr = 4'd15; it.clr = 1'b0; it.irqChk = 1'b1; it.exp = {7'd0, e}; it.req = r;
    q.push_back(it);
    wait (q.size() == 0);
    @(posedge clk);
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bitValid = 1'b0; regAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic sendBit(input logic b, input logic f);
    @(negedge clk);
    bitIn = b; frameMark = f; bitValid = 1'b1;
  endtask

  task automatic idle();
    @(negedge clk);
    bitValid = 1'b0; frameMark = 1'b0;
  endtask

  function automatic logic patBit(input int len, input logic [15:0] code, input int p);
    return (len == 16) ? code[15-p] : code[len-1-p];
  endfunction

  task automatic sendCode(input int len, input logic [15:0] code, input int n, input int nErr);
    int errs = 0;
    for (int i = 0; i < n; i++) begin
      logic b = patBit(len, code, ph);
      if (nErr > 0 && errs < nErr && i % (n / nErr) == 0) begin b = ~b; errs++; end
      sendBit(b, 1'b0);
      ph = (ph + 1) % len;
    end
    idle();
  endtask

  task automatic sendInserted(input int len, input logic [15:0] code, input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      if (i % gap == gap - 1) sendBit(1'b1, 1'b1);
      sendBit(patBit(len, code, ph), 1'b0);
      ph = (ph + 1) % len;
    end
    idle();
  endtask

  task automatic sendOverwrite(input int len, input logic [15:0] code, input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      logic b = patBit(len, code, ph);
      if (i % gap == gap - 1) sendBit(~b, 1'b1);
      else sendBit(b, 1'b0);
      ph = (ph + 1) % len;
    end
    idle();
  endtask

  task automatic restartAll();
    writeReg(4'd4, 8'h01);
    writeReg(4'd6, 8'h01);
    writeReg(4'd8, 8'hF0);
    ph = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R9: reset state
    expectReg(4'd10, 8'h00, "R9 rt");
    expectReg(4'd11, 8'h00, "R9 lset");
    expectReg(4'd12, 8'h00, "R9 lclr");
    expectIrq(1'b0, "R9 irq");

    // R1 configuration: up 00001 (len 5), down 001 (len 3), spare F0C3 (len 16)
    writeReg(4'd0, 8'h04);
    writeReg(4'd1, 8'h02);
    writeReg(4'd2, 8'h08);
    writeReg(4'd9, 8'hC3);
    restartAll();

    // R2: no detection before the window ends, detection at its last bit
    sendCode(5, 16'h0001, W - 1, 0);
    expectReg(4'd10, 8'h00, "R2 before window end");
    sendCode(5, 16'h0001, 1, 0);
    expectReg(4'd10, 8'h01, "R2 R1 up detected at window end");

    // R7 / R8: latched set, mask, read-clear
    expectReg(4'd11, 8'h01, "R7 lset after rise");
    expectIrq(1'b0, "R8 masked off");
    writeReg(4'd13, 8'h01);
    expectIrq(1'b1, "R8 set mask enabled");
    expectReg(4'd11, 8'h01, "R7 lset read", 1'b1);
    expectReg(4'd11, 8'h00, "R7 lset cleared by read");
    expectIrq(1'b0, "R8 irq after clear");

    // R3: threshold of W/50 mismatches
    sendCode(5, 16'h0001, W, 4);
    expectReg(4'd10, 8'h01, "R3 at limit stays present");
    sendCode(5, 16'h0001, W, 5);
    expectReg(4'd10, 8'h00, "R3 above limit clears");
    expectReg(4'd12, 8'h01, "R7 lclr after fall");
    writeReg(4'd13, 8'h10);
    expectIrq(1'b1, "R8 clear mask enabled");
    expectReg(4'd12, 8'h01, "R7 lclr read", 1'b1);
    expectReg(4'd12, 8'h00, "R7 lclr cleared by read");

    // R4: insert mode skips marked bits
    writeReg(4'd3, 8'h01);
    restartAll();
    sendInserted(3, 16'h0001, W, 10);
    expectReg(4'd10, 8'h02, "R4 down detected with inserted frame bits");

    // R5: overwrite mode excludes marked bits from the error count
    writeReg(4'd3, 8'h00);
    restartAll();
    sendOverwrite(16, 16'hF0C3, W, 8);
    expectReg(4'd10, 8'h04, "R5 R1 spare detected with overwritten bits");

    // R6: code write restarts only that detector's window
    restartAll();
    for (int i = 0; i < W; i++) sendBit(1'b0, 1'b0);
    idle();
    expectReg(4'd10, 8'h00, "R3 all-zero stream absent");
    for (int i = 0; i < 150; i++) sendBit(1'b0, 1'b0);
    idle();
    writeReg(4'd8, 8'hF0);
    ph = 0;
    sendCode(16, 16'hF0C3, W, 0);
    expectReg(4'd10, 8'h04, "R6 spare restarted by code write");

    // R1 / R6: one-bit length, written length restarts the detector
    writeReg(4'd0, 8'h00);
    writeReg(4'd6, 8'h01);
    writeReg(4'd8, 8'hF0);
    ph = 0;
    sendCode(1, 16'h0001, W, 4);
    expectReg(4'd10, 8'h01, "R1 one-bit code detected");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule